// File: doc/BRIEF.md
# EPROM Byte Burn Sequencer

This block programs an external parallel EPROM one byte at a time. A single start pulse makes it walk a fixed address window. For each address it asks a byte source for the data. It then repeats short programming pulses, reading the cell back after each one, until the byte reads correctly. It finishes that address with one extra programming pulse whose length grows with the number of pulses the byte needed. When every address has been burned, it switches the supply select to read levels and reads the whole window back once more. While it runs, the block owns the chip-enable, output-enable and program strobes, the address bus and the write side of the data bus.

The base pulse, the setup time and the read access time are set in microseconds or nanoseconds. A clocks-per-microsecond parameter turns them into cycle counts. A byte that still fails after the pulse limit ends the run with a failure. So does any mismatch in the final read-back. In both cases the offending address is reported. The status stays unchanged until the next start.

Top module: `prom_prog_seq`

## Requirements
- R1: While reset is asserted and after it is released, ceN, oeN and pgmN are high, romDataOe is 0, supplyProg is 0 (read levels), and busy, done, pass and fail are 0.
- R2: During every program pulse, supplyProg is 1, ceN is low, oeN is high and the data bus carries the byte for the current address. Address and data are presented for at least SETUP_US·CLK_PER_US cycles before pgmN falls. Each base pulse holds pgmN low for exactly PULSE_US·CLK_PER_US cycles.
- R3: After every base pulse, the block reads the cell exactly once, with oeN low, pgmN high and the data bus released. It compares the value on romDataIn with the intended byte.
- R4: The number of base pulses applied to an address equals the number of pulses that address needs before it reads correctly, as long as that number is at most MAX_PULSES.
- R5: If a byte still reads wrong after its MAX_PULSES-th pulse (25 by default), no further pulse is applied. The run ends with done=1, fail=1, pass=0 and failAddr equal to that address.
- R6: Once a byte verifies after X pulses, a single continuous over-program pulse follows with pgmN low for X·PULSE_US·CLK_PER_US cycles. The address advances only after that pulse.
- R7: Addresses are visited in increasing order from ADDR_FIRST to ADDR_LAST. For each visit the block asks for a byte with srcReq and takes srcData in the cycle srcValid is 1. One byte is fetched per address in each pass.
- R8: After ADDR_LAST is burned, supplyProg drops to 0. Every address is read back once in increasing order. The first mismatch ends the run with done=1, fail=1 and failAddr equal to that address.
- R9: romDataOe is 1 only while ceN is low and oeN is high. The data bus is released in the cycle before oeN falls.
- R10: done, pass, fail and failAddr stay constant from the end of a run until the next start. A start clears them in the cycle it is accepted.
- R11: If every address verifies in the final read-back, the run ends with done=1, pass=1 and fail=0. pass and fail are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start a run (accepted when idle) |
| srcReq | output | 1 | Byte wanted for the address on romAddr |
| srcValid | input | 1 | srcData is valid this cycle |
| srcData | input | 8 | Image byte for the requested address |
| romAddr | output | 17 | EPROM address |
| romDataOut | output | 8 | Byte driven towards the EPROM |
| romDataOe | output | 1 | Drive enable for romDataOut |
| romDataIn | input | 8 | Byte read back from the EPROM |
| ceN | output | 1 | Chip enable, active low |
| oeN | output | 1 | Output enable, active low |
| pgmN | output | 1 | Program strobe, active low |
| supplyProg | output | 1 | 1 = programming supply levels, 0 = read levels |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with every byte correct |
| fail | output | 1 | Run finished with a failure |
| failAddr | output | 17 | Address that caused the failure |

## Verification
Two events can land on the same decision cycle, and the bench aims at both. In the first, a byte verifies on exactly its limit pulse; the sequencer must take the over-program branch, not the failure branch. In the second, the last address finishes its over-program pulse; the sequencer must step into the read-level pass, not on to a next address. The bench provokes these with vectors that have one byte needing exactly 25 pulses, one needing 26, and a burn that ends on the top address of the window. A small EPROM model counts the pulses and measures their lengths, and the expected pulse counts, over-program lengths, read counts, fetch counts, status and failing address are derived from the pulse needs in the table.

// File: rtl/prom_prog_pkg.sv
package prom_prog_pkg;

  typedef enum logic [1:0] {
    TSEL_SETUP = 2'd0,
    TSEL_PULSE = 2'd1,
    TSEL_READ  = 2'd2
  } timerSel_e;

  typedef struct packed {
    logic      addrLoad;
    logic      addrInc;
    logic      dataLatch;
    logic      xClr;
    logic      xInc;
    logic      timerLoad;
    timerSel_e timerSel;
    logic      repLoad;
    logic      repDec;
    logic      sample;
    logic      statusClr;
    logic      setPass;
    logic      setFail;
  } strobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prom_prog_dpath.sv
module prom_prog_dpath
  import prom_prog_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int MAX_PULSES = 25,
  parameter int SETUP_CYC = 50,
  parameter int PULSE_CYC = 5000,
  parameter int READ_CYC = 5,
  parameter logic [ADDR_W-1:0] ADDR_FIRST = 17'h01000,
  parameter logic [ADDR_W-1:0] ADDR_LAST = 17'h1FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] romDataIn,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] romDataOut,
  output logic              timerDone,
  output logic              repLast,
  output logic              xAtMax,
  output logic              atLast,
  output logic              matchQ,
  output logic              doneQ,
  output logic              passQ,
  output logic              failQ,
  output logic [ADDR_W-1:0] failAddrQ
);

  localparam int CW = $clog2(MAX_PULSES + 1);
  localparam int TMAX = maxOf(maxOf(SETUP_CYC, PULSE_CYC), READ_CYC);
  localparam int TW = $clog2(TMAX + 1);
  localparam logic [TW-1:0] SETUP_LD = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] PULSE_LD = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] READ_LD  = TW'(READ_CYC - 1);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [CW-1:0]     xCnt;
  logic [CW-1:0]     repQ;
  logic [TW-1:0]     timerQ;
  logic [TW-1:0]     loadVal;

  // address walker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              addrQ <= ADDR_FIRST;
    else if (strb.addrLoad) addrQ <= ADDR_FIRST;
    else if (strb.addrInc)  addrQ <= addrQ + ADDR_W'(1);
  end

  assign romAddr = addrQ;
  assign atLast  = (addrQ == ADDR_LAST);

  // image byte for the current address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dataQ <= '0;
    else if (strb.dataLatch) dataQ <= srcData;
  end

  assign romDataOut = dataQ;

  // pulse counter X
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          xCnt <= '0;
    else if (strb.xClr) xCnt <= '0;
    else if (strb.xInc) xCnt <= xCnt + CW'(1);
  end

  assign xAtMax = (xCnt == CW'(MAX_PULSES));

  // repetitions left in the over-program pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             repQ <= '0;
    else if (strb.repLoad) repQ <= xCnt;
    else if (strb.repDec)  repQ <= repQ - CW'(1);
  end

  assign repLast = (repQ == CW'(1));

  // shared interval timer
  always_comb begin
    case (strb.timerSel)
      TSEL_PULSE: loadVal = PULSE_LD;
      TSEL_READ:  loadVal = READ_LD;
      default:    loadVal = SETUP_LD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               timerQ <= '0;
    else if (strb.timerLoad) timerQ <= loadVal;
    else if (timerQ != '0)   timerQ <= timerQ - TW'(1);
  end

  assign timerDone = (timerQ == '0);

  // read-back compare
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            matchQ <= 1'b0;
    else if (strb.sample) matchQ <= (romDataIn == dataQ);
  end

  // run status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ     <= 1'b0;
      passQ     <= 1'b0;
      failQ     <= 1'b0;
      failAddrQ <= '0;
    end else if (strb.statusClr) begin
      doneQ     <= 1'b0;
      passQ     <= 1'b0;
      failQ     <= 1'b0;
      failAddrQ <= '0;
    end else if (strb.setFail) begin
      doneQ     <= 1'b1;
      failQ     <= 1'b1;
      failAddrQ <= addrQ;
    end else if (strb.setPass) begin
      doneQ     <= 1'b1;
      passQ     <= 1'b1;
    end
  end

  assert_xcnt_limit_R5: assert property (@(posedge clk) disable iff (!rstN)
    xCnt <= CW'(MAX_PULSES));

  assert_addr_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    (addrQ >= ADDR_FIRST) && (addrQ <= ADDR_LAST));

  assert_status_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(passQ && failQ));

  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !strb.statusClr) |=> (doneQ && $stable(passQ) && $stable(failQ) && $stable(failAddrQ)));

endmodule

// File: rtl/prom_prog_ctrl.sv
module prom_prog_ctrl
  import prom_prog_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    srcValid,
  input  logic    timerDone,
  input  logic    repLast,
  input  logic    xAtMax,
  input  logic    atLast,
  input  logic    matchQ,
  output strobe_t strb,
  output logic    srcReq,
  output logic    ceN,
  output logic    oeN,
  output logic    pgmN,
  output logic    dataDrive,
  output logic    supplyProg,
  output logic    busy
);

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_WSETUP, S_PULSE, S_VSETUP,
    S_VREAD, S_JUDGE, S_OSETUP, S_OPULSE
  } state_e;

  state_e state, stateNext;
  logic   verifyPhase;
  logic   enterVerify;
  logic   leaveVerify;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      verifyPhase <= 1'b0;
    end else begin
      state <= stateNext;
      if (leaveVerify)      verifyPhase <= 1'b0;
      else if (enterVerify) verifyPhase <= 1'b1;
    end
  end

  always_comb begin
    strb        = '0;
    stateNext   = state;
    enterVerify = 1'b0;
    leaveVerify = 1'b0;
    case (state)
      S_IDLE: begin
        if (startReq) begin
          strb.addrLoad  = 1'b1;
          strb.statusClr = 1'b1;
          leaveVerify    = 1'b1;
          stateNext      = S_FETCH;
        end
      end
      S_FETCH: begin
        if (srcValid) begin
          strb.dataLatch = 1'b1;
          strb.xClr      = 1'b1;
          strb.timerLoad = 1'b1;
          strb.timerSel  = TSEL_SETUP;
          stateNext      = verifyPhase ? S_VSETUP : S_WSETUP;
        end
      end
      S_WSETUP: begin
        if (timerDone) begin
          strb.timerLoad = 1'b1;
          strb.timerSel  = TSEL_PULSE;
          stateNext      = S_PULSE;
        end
      end
      S_PULSE: begin
        if (timerDone) begin
          strb.xInc      = 1'b1;
          strb.timerLoad = 1'b1;
          strb.timerSel  = TSEL_SETUP;
          stateNext      = S_VSETUP;
        end
      end
      S_VSETUP: begin
        if (timerDone) begin
          strb.timerLoad = 1'b1;
          strb.timerSel  = TSEL_READ;
          stateNext      = S_VREAD;
        end
      end
      S_VREAD: begin
        if (timerDone) begin
          strb.sample = 1'b1;
          stateNext   = S_JUDGE;
        end
      end
      S_JUDGE: begin
        if (verifyPhase) begin
          if (!matchQ) begin
            strb.setFail = 1'b1;
            stateNext    = S_IDLE;
          end else if (atLast) begin
            strb.setPass = 1'b1;
            stateNext    = S_IDLE;
          end else begin
            strb.addrInc = 1'b1;
            stateNext    = S_FETCH;
          end
        end else if (matchQ) begin
          strb.timerLoad = 1'b1;
          strb.timerSel  = TSEL_SETUP;
          stateNext      = S_OSETUP;
        end else if (xAtMax) begin
          strb.setFail = 1'b1;
          stateNext    = S_IDLE;
        end else begin
          strb.timerLoad = 1'b1;
          strb.timerSel  = TSEL_SETUP;
          stateNext      = S_WSETUP;
        end
      end
      S_OSETUP: begin
        if (timerDone) begin
          strb.timerLoad = 1'b1;
          strb.timerSel  = TSEL_PULSE;
          strb.repLoad   = 1'b1;
          stateNext      = S_OPULSE;
        end
      end
      S_OPULSE: begin
        if (timerDone) begin
          if (repLast) begin
            if (atLast) begin
              strb.addrLoad = 1'b1;
              enterVerify   = 1'b1;
            end else begin
              strb.addrInc  = 1'b1;
            end
            stateNext = S_FETCH;
          end else begin
            strb.repDec    = 1'b1;
            strb.timerLoad = 1'b1;
            strb.timerSel  = TSEL_PULSE;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy       = (state != S_IDLE);
  assign srcReq     = (state == S_FETCH);
  assign ceN        = (state == S_IDLE) || (state == S_FETCH);
  assign oeN        = (state != S_VREAD);
  assign pgmN       = !((state == S_PULSE) || (state == S_OPULSE));
  assign dataDrive  = (state == S_WSETUP) || (state == S_PULSE) ||
                      (state == S_OSETUP) || (state == S_OPULSE);
  assign supplyProg = busy && !verifyPhase;

  assert_bus_turnaround_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oeN) |-> (!dataDrive && !$past(dataDrive)));

  assert_pulse_preceded_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pgmN) |-> ($past(dataDrive) && !$past(ceN) && supplyProg));

  assert_no_pgm_during_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> (pgmN && !ceN));

  assert_read_levels_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!oeN && verifyPhase) |-> !supplyProg);

endmodule

// File: rtl/prom_prog_seq.sv
module prom_prog_seq
  import prom_prog_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CLK_PER_US = 25,
  parameter int PULSE_US = 200,
  parameter int SETUP_US = 2,
  parameter int READ_NS = 150,
  parameter int MAX_PULSES = 25,
  parameter logic [ADDR_W-1:0] ADDR_FIRST = 17'h01000,
  parameter logic [ADDR_W-1:0] ADDR_LAST = 17'h1FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  output logic              srcReq,
  input  logic              srcValid,
  input  logic [DATA_W-1:0] srcData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] romDataOut,
  output logic              romDataOe,
  input  logic [DATA_W-1:0] romDataIn,
  output logic              ceN,
  output logic              oeN,
  output logic              pgmN,
  output logic              supplyProg,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr
);

  localparam int SETUP_CYC = SETUP_US * CLK_PER_US;
  localparam int PULSE_CYC = PULSE_US * CLK_PER_US;
  localparam int READ_CYC  = (CLK_PER_US * READ_NS + 999) / 1000 + 1;

  strobe_t strb;
  logic    timerDone, repLast, xAtMax, atLast, matchQ;

  prom_prog_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .srcValid   (srcValid),
    .timerDone  (timerDone),
    .repLast    (repLast),
    .xAtMax     (xAtMax),
    .atLast     (atLast),
    .matchQ     (matchQ),
    .strb       (strb),
    .srcReq     (srcReq),
    .ceN        (ceN),
    .oeN        (oeN),
    .pgmN       (pgmN),
    .dataDrive  (romDataOe),
    .supplyProg (supplyProg),
    .busy       (busy)
  );

  prom_prog_dpath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .MAX_PULSES (MAX_PULSES),
    .SETUP_CYC  (SETUP_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .READ_CYC   (READ_CYC),
    .ADDR_FIRST (ADDR_FIRST),
    .ADDR_LAST  (ADDR_LAST)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .srcData    (srcData),
    .romDataIn  (romDataIn),
    .romAddr    (romAddr),
    .romDataOut (romDataOut),
    .timerDone  (timerDone),
    .repLast    (repLast),
    .xAtMax     (xAtMax),
    .atLast     (atLast),
    .matchQ     (matchQ),
    .doneQ      (done),
    .passQ      (pass),
    .failQ      (fail),
    .failAddrQ  (failAddr)
  );

endmodule

// File: tb/sim_prom_prog_seq.sv
module sim_prom_prog_seq;

  localparam int CPU = 1;
  localparam int PUS = 4;
  localparam int SUS = 2;
  localparam int PLEN = PUS * CPU;
  localparam int LIMIT = 25;
  localparam logic [16:0] BFIRST = 17'h1FFFC;
  localparam logic [16:0] BLAST  = 17'h1FFFF;
  localparam int NV = 4;
  // columns: need0 need1 need2 need3 weakIdx srcDelay expPass expFailIdx
  localparam int VT [NV][8] = '{
    '{1, 1, 1, 1,  4, 0, 1, 4},
    '{3, 7, 1, 25, 4, 2, 1, 4},
    '{2, 26, 1, 1, 4, 1, 0, 1},
    '{1, 2, 3, 4,  2, 0, 0, 2}
  };

  logic        clk, rstN, startReq, srcReq, srcValid;
  logic [7:0]  srcData, romDataOut, romDataIn;
  logic [16:0] romAddr, failAddr;
  logic        romDataOe, ceN, oeN, pgmN, supplyProg, busy, done, pass, fail;

  int nChk, nBad;
  int hard [4];
  int pulses [4];
  int ovLen [4];
  int weakIdx, srcDly, wcnt;
  int lenErr, drvErr, busErr, progReads, verReads, fetchCnt;
  int lowLen, curIdx, cycles;
  logic prevOeN;

  prom_prog_seq #(
    .CLK_PER_US (CPU), .PULSE_US (PUS), .SETUP_US (SUS), .READ_NS (150),
    .MAX_PULSES (LIMIT), .ADDR_FIRST (BFIRST), .ADDR_LAST (BLAST)
  ) u0 (
    .clk (clk), .rstN (rstN), .startReq (startReq), .srcReq (srcReq),
    .srcValid (srcValid), .srcData (srcData), .romAddr (romAddr),
    .romDataOut (romDataOut), .romDataOe (romDataOe), .romDataIn (romDataIn),
    .ceN (ceN), .oeN (oeN), .pgmN (pgmN), .supplyProg (supplyProg),
    .busy (busy), .done (done), .pass (pass), .fail (fail), .failAddr (failAddr)
  );

  function automatic logic [7:0] imgByte(input logic [16:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // EPROM model: a cell reads back correctly once it has had enough pulses;
  // the weak cell reads wrong at read supply levels
  always_comb begin
    romDataIn = 8'hFF;
    if (!ceN && !oeN) begin
      if (pulses[romAddr[1:0]] >= hard[romAddr[1:0]]) romDataIn = imgByte(romAddr);
      if (!supplyProg && (int'(romAddr[1:0]) == weakIdx)) romDataIn = romDataIn ^ 8'h01;
    end
  end

  // pulse, read and bus monitor
  always @(negedge clk) begin
    cycles++;
    if (!rstN) begin
      lowLen  = 0;
      prevOeN = 1'b1;
    end else begin
      if (romDataOe && (ceN || !oeN)) busErr++;
      if (!pgmN) begin
        if (lowLen == 0) begin
          curIdx = int'(romAddr[1:0]);
          if (!romDataOe || romDataOut != imgByte(romAddr) || !supplyProg || ceN || !oeN) drvErr++;
        end
        lowLen++;
      end else if (lowLen > 0) begin
        if (pulses[curIdx] < hard[curIdx]) begin
          if (lowLen != PLEN) lenErr++;
          pulses[curIdx]++;
        end else begin
          ovLen[curIdx] = lowLen;
        end
        lowLen = 0;
      end
      if (!oeN && prevOeN) begin
        if (romDataOe || !pgmN) drvErr++;
        if (supplyProg) progReads++;
        else verReads++;
      end
      prevOeN = oeN;
    end
  end

  // byte source with a programmable wait
  always @(negedge clk) begin
    if (!rstN) begin
      srcValid = 1'b0;
      srcData  = 8'h00;
      wcnt     = 0;
    end else if (srcValid) begin
      srcValid = 1'b0;
    end else if (srcReq) begin
      if (wcnt >= srcDly) begin
        srcValid = 1'b1;
        srcData  = imgByte(romAddr);
        fetchCnt++;
        wcnt     = 0;
      end else begin
        wcnt++;
      end
    end
  end

  // watchdog
  always @(negedge clk) begin
    if (cycles > 190000) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  task automatic clearModel();
    for (int i = 0; i < 4; i++) begin
      pulses[i] = 0;
      ovLen[i]  = 0;
    end
    lenErr = 0; drvErr = 0; busErr = 0;
    progReads = 0; verReads = 0; fetchCnt = 0;
  endtask

  task automatic kick();
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk("R10", "done cleared by start", int'(done), 0);
    chk("R10", "fail cleared by start", int'(fail), 0);
  endtask

  task automatic waitDone();
    int n;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk("R7", "run completed", int'(done), 1);
  endtask

  initial begin
    nChk = 0; nBad = 0; cycles = 0;
    rstN = 1'b0; startReq = 1'b0; weakIdx = 4; srcDly = 0;
    for (int i = 0; i < 4; i++) hard[i] = 1;
    clearModel();
    repeat (3) @(negedge clk);
    chk("R1", "ceN in reset", int'(ceN), 1);
    chk("R1", "oeN in reset", int'(oeN), 1);
    chk("R1", "pgmN in reset", int'(pgmN), 1);
    chk("R1", "bus drive in reset", int'(romDataOe), 0);
    chk("R1", "supply select in reset", int'(supplyProg), 0);
    chk("R1", "busy/done in reset", int'({busy, done, pass, fail}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", int'({busy, done, ceN, pgmN}), 3);

    for (int v = 0; v < NV; v++) begin
      int pf, expPulseSum, expReads;
      int expPulse [4];
      int expOv [4];
      for (int i = 0; i < 4; i++) hard[i] = VT[v][i];
      weakIdx = VT[v][4];
      srcDly  = VT[v][5];
      clearModel();
      pf = 4;
      for (int i = 3; i >= 0; i--) if (hard[i] > LIMIT) pf = i;
      expPulseSum = 0;
      for (int i = 0; i < 4; i++) begin
        expPulse[i] = (i < pf) ? hard[i] : ((i == pf) ? LIMIT : 0);
        expOv[i]    = (i < pf) ? hard[i] * PLEN : 0;
        expPulseSum += expPulse[i];
      end
      expReads = (pf < 4) ? 0 : ((weakIdx < 4) ? weakIdx + 1 : 4);

      kick();
      waitDone();
      chk("R11", $sformatf("vec%0d pass", v), int'(pass), VT[v][6]);
      chk("R5", $sformatf("vec%0d fail", v), int'(fail), 1 - VT[v][6]);
      if (VT[v][6] == 0) begin
        if (pf < 4) chk("R5", $sformatf("vec%0d failAddr", v), int'(failAddr), int'(BFIRST) + VT[v][7]);
        else        chk("R8", $sformatf("vec%0d failAddr", v), int'(failAddr), int'(BFIRST) + VT[v][7]);
      end
      for (int i = 0; i < 4; i++) begin
        chk("R4", $sformatf("vec%0d base pulses @%0d", v, i), pulses[i], expPulse[i]);
        chk("R6", $sformatf("vec%0d over-program length @%0d", v, i), ovLen[i], expOv[i]);
      end
      chk("R2", $sformatf("vec%0d base pulse length errors", v), lenErr, 0);
      chk("R2", $sformatf("vec%0d pulse environment errors", v), drvErr, 0);
      chk("R3", $sformatf("vec%0d verify reads", v), progReads, expPulseSum);
      chk("R8", $sformatf("vec%0d read-level reads", v), verReads, expReads);
      chk("R7", $sformatf("vec%0d byte fetches", v), fetchCnt, ((pf < 4) ? pf + 1 : 4) + expReads);
      chk("R9", $sformatf("vec%0d bus contention cycles", v), busErr, 0);
      chk("R8", $sformatf("vec%0d supply after run", v), int'(supplyProg), 0);
      begin
        logic [16:0] fa;
        logic [2:0]  st;
        fa = failAddr;
        st = {done, pass, fail};
        repeat (40) @(negedge clk);
        chk("R10", $sformatf("vec%0d status held", v), int'({done, pass, fail}), int'(st));
        chk("R10", $sformatf("vec%0d failAddr held", v), int'(failAddr), int'(fa));
      end
    end

    // reset in the middle of a burn
    for (int i = 0; i < 4; i++) hard[i] = 3;
    weakIdx = 4; srcDly = 0;
    clearModel();
    kick();
    repeat (15) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1", "strobes after mid-run reset", int'({ceN, oeN, pgmN}), 7);
    chk("R1", "bus and status after mid-run reset", int'({romDataOe, supplyProg, busy, done}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "stays idle after mid-run reset", int'({busy, done}), 0);

    // restart from the start of the window after the interrupted burn
    clearModel();
    for (int i = 0; i < 4; i++) hard[i] = 1;
    kick();
    waitDone();
    chk("R11", "rerun pass", int'(pass), 1);
    chk("R7", "rerun fetches", fetchCnt, 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule